// File: doc/BRIEF.md
# Character Display Register Interface

This block is the host-side register interface of a four-character alphanumeric display controller. A host accesses it like a small peripheral. It has two chip enables of opposite polarity, a 3-bit address, active-low read and write strobes and an 8-bit bidirectional data bus. The block holds four character words and one control word. It drives the bus only during a valid read.

All strobes are sampled by the system clock through a two-flop synchronizer. A write commits once, on the falling edge of the synchronized write strobe. The stored words and the decoded control fields are presented continuously to a downstream scan block.

Setting the clear bit in the control word fills the character memory with spaces. Both setting and releasing the clear bit open a busy window of a programmable number of cycles. During that window every write is dropped.

Top module: `chardisp_regif`

## Requirements
- R1: A synchronous active-high reset sets every character word and the control word to 0x00, and deasserts busy.
- R2: The block is selected only when `ce0_n`=0 and `ce1`=1. Under any other combination, writes have no effect and the bus is not driven.
- R3: With `addr[2]`=1, `addr[1:0]` values 0 to 3 select character words 0 to 3. Any address with `addr[2]`=0 selects the control word.
- R4: In a character word, bits 6..0 hold the character code and bit 7 is the highlight attribute. All 8 bits read back as written. `chars_o[8*i+7:8*i]` carries word i.
- R5: Control word bit fields are: bits 1..0 brightness (`bright_o`), bit 4 blink enable, bit 5 blink-all, bit 6 lamp test and bit 7 clear. The full byte reads back as written.
- R6: While the block is selected, the synchronized read strobe is low and the synchronized write strobe is high, the block drives the addressed word onto `data_io`.
- R7: When both strobes are low together, no word is written and the bus is not driven.
- R8: A write commits exactly once per write-strobe low period, three clock edges after the strobe falls. Data that changes while the strobe is still held low is not stored.
- R9: A control write with bit 7 set fills all four character words with 0x20 and raises `busy_o`.
- R10: A control write with bit 7 clear, made while the stored clear bit is set, ends the clear and raises `busy_o` again. Character writes then take effect once busy has dropped.
- R11: While `busy_o` is high, writes to any address are ignored.
- R12: While the stored clear bit is set, character writes are ignored, so character words read back as 0x20.
- R13: `busy_o` stays high for CLR_CYCLES clock cycles after the committing edge, then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| data_io | inout | 8 | Bidirectional data bus |
| chars_o | output | 32 | Four character words, word i at bits 8i+7..8i |
| bright_o | output | 2 | Brightness field |
| blink_en_o | output | 1 | Blink enable for attributed characters |
| blink_all_o | output | 1 | Blink all characters |
| lamp_test_o | output | 1 | Lamp test |
| clear_o | output | 1 | Stored clear bit |
| busy_o | output | 1 | Clear window in progress |

## Verification
The vector table writes distinct bytes to every character address and to the control word. It then reads them all back after the full sequence. This separates correct address decode from aliasing, and a set attribute bit exposes any loss of bit 7. Deselected writes, overlapping strobes and a held strobe with data changing mid-pulse each target a different part of the write qualification. The clear sequence is entered with writes pending during busy and while the clear bit is held. This separates the timer window from the clear-bit lockout, and it also checks that both edges of the clear bit re-arm the timer.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    localparam int NUM_CHARS  = 4;
    localparam int WORD_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int IDX_W      = $clog2(NUM_CHARS);
    localparam logic [WORD_W-1:0] BLANK_CHAR = 8'h20;

    typedef struct packed {
        logic       attr;
        logic [6:0] code;
    } char_word_t;

    typedef struct packed {
        logic       clear;
        logic       lamp_test;
        logic       blink_all;
        logic       blink_en;
        logic [1:0] spare;
        logic [1:0] bright;
    } ctrl_word_t;

    function automatic logic is_char_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic logic [IDX_W-1:0] char_index(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/chardisp_strobe_sync.sv
module chardisp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_low,
    output logic wr_low,
    output logic wr_fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] rd_sh;
    logic [DEPTH-1:0] wr_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sh <= '1;
            wr_sh <= '1;
        end else begin
            rd_sh <= {rd_sh[DEPTH-2:0], rd_n};
            wr_sh <= {wr_sh[DEPTH-2:0], wr_n};
        end
    end

    assign rd_low  = !rd_sh[STAGES-1];
    assign wr_low  = !wr_sh[STAGES-1];
    assign wr_fall = !wr_sh[STAGES-1] && wr_sh[STAGES];

    // R8: one commit per strobe pulse
    a_r8_single_commit: assert property (@(posedge clk) disable iff (rst)
        wr_fall |=> !wr_fall);

endmodule

// File: rtl/chardisp_clear_timer.sv
module chardisp_clear_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R9: a start always opens the window
    a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R13: the window only closes when it was not just restarted
    a_r13_busy_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(start));

endmodule

// File: rtl/chardisp_regfile.sv
module chardisp_regfile
    import chardisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic              clr_start,
    output char_word_t        chars [NUM_CHARS],
    output ctrl_word_t        ctrl,
    output logic [WORD_W-1:0] rdata
);
    logic write_ok;
    logic hit_char;

    assign write_ok  = wr_fire && !busy;
    assign hit_char  = is_char_addr(addr);
    assign clr_start = write_ok && !hit_char && (wdata[WORD_W-1] || ctrl.clear);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (write_ok && !hit_char) begin
            ctrl <= ctrl_word_t'(wdata);
        end
    end

    generate
        for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
            always_ff @(posedge clk) begin
                if (rst) begin
                    chars[i] <= '0;
                end else if (write_ok && !hit_char && wdata[WORD_W-1]) begin
                    chars[i] <= char_word_t'(BLANK_CHAR);
                end else if (write_ok && hit_char && !ctrl.clear
                             && char_index(addr) == IDX_W'(i)) begin
                    chars[i] <= char_word_t'(wdata);
                end
            end
        end
    endgenerate

    always_comb begin
        if (hit_char)
            rdata = chars[char_index(addr)];
        else
            rdata = ctrl;
    end

    // R11: nothing changes on a write issued during the busy window
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && busy) |=> ($stable(ctrl) && $stable(chars[0]) && $stable(chars[1])
                               && $stable(chars[2]) && $stable(chars[3])));

    // R12: character writes are locked out while clear is held
    a_r12_clear_lock: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && hit_char && ctrl.clear) |=> ($stable(chars[0]) && $stable(chars[1])
                                                 && $stable(chars[2]) && $stable(chars[3])));

endmodule

// File: rtl/chardisp_regif.sv
module chardisp_regif
    import chardisp_pkg::*;
#(
    parameter int CLR_CYCLES  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce0_n,
    input  logic        ce1,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [2:0]  addr,
    inout  wire  [7:0]  data_io,
    output logic [31:0] chars_o,
    output logic [1:0]  bright_o,
    output logic        blink_en_o,
    output logic        blink_all_o,
    output logic        lamp_test_o,
    output logic        clear_o,
    output logic        busy_o
);
    logic              rd_low;
    logic              wr_low;
    logic              wr_fall;
    logic              sel;
    logic              wr_fire;
    logic              drive_en;
    logic              clr_start;
    logic              busy;
    char_word_t        chars [NUM_CHARS];
    ctrl_word_t        ctrl;
    logic [WORD_W-1:0] rdata;

    chardisp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .rd_low (rd_low),
        .wr_low (wr_low),
        .wr_fall(wr_fall)
    );

    assign sel      = !ce0_n && ce1;
    assign wr_fire  = wr_fall && sel && !rd_low;
    assign drive_en = sel && rd_low && !wr_low;

    chardisp_clear_timer #(.CYCLES(CLR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(clr_start),
        .busy (busy)
    );

    chardisp_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_fire  (wr_fire),
        .addr     (addr),
        .wdata    (data_io),
        .busy     (busy),
        .clr_start(clr_start),
        .chars    (chars),
        .ctrl     (ctrl),
        .rdata    (rdata)
    );

    assign data_io = drive_en ? rdata : 'z;

    generate
        for (genvar i = 0; i < NUM_CHARS; i++) begin : g_out
            assign chars_o[WORD_W*i +: WORD_W] = chars[i];
        end
    endgenerate

    assign bright_o    = ctrl.bright;
    assign blink_en_o  = ctrl.blink_en;
    assign blink_all_o = ctrl.blink_all;
    assign lamp_test_o = ctrl.lamp_test;
    assign clear_o     = ctrl.clear;
    assign busy_o      = busy;

endmodule

// File: tb/chardisp_regif_bench.sv
module chardisp_regif_bench;
    localparam int CLR = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce0_n = 1'b0;
    logic        ce1 = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  tb_dq = '0;
    logic        tb_oe = 1'b0;
    wire  [7:0]  data_io;
    logic [31:0] chars_o;
    logic [1:0]  bright_o;
    logic        blink_en_o, blink_all_o, lamp_test_o, clear_o, busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign data_io = tb_oe ? tb_dq : 8'bz;

    always #5 clk = ~clk;

    chardisp_regif #(.CLR_CYCLES(CLR)) u_chardisp_regif (
        .clk(clk), .rst(rst), .ce0_n(ce0_n), .ce1(ce1), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .data_io(data_io), .chars_o(chars_o), .bright_o(bright_o),
        .blink_en_o(blink_en_o), .blink_all_o(blink_all_o), .lamp_test_o(lamp_test_o),
        .clear_o(clear_o), .busy_o(busy_o)
    );

    // {address, data}
    localparam logic [10:0] VEC [5] = '{
        {3'b100, 8'hC1}, {3'b101, 8'h57}, {3'b110, 8'h66},
        {3'b111, 8'h33}, {3'b000, 8'h5E}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; tb_dq = d; tb_oe = 1'b1; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        tb_oe = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = data_io;
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 chars", chars_o, 32'h0);
        check("R1 busy", {31'b0, busy_o}, 32'h0);
        bus_read(3'b000, rv);
        check("R1 ctrl read", {24'b0, rv}, 32'h0);

        // R3 R4 R5 vector table: write then read each
        for (int i = 0; i < 5; i++) begin
            bus_write(VEC[i][10:8], VEC[i][7:0]);
            bus_read(VEC[i][10:8], rv);
            check("R3 write/read", {24'b0, rv}, {24'b0, VEC[i][7:0]});
        end
        for (int i = 0; i < 5; i++) begin
            bus_read(VEC[i][10:8], rv);
            check("R3 no alias", {24'b0, rv}, {24'b0, VEC[i][7:0]});
        end
        bus_read(3'b011, rv);
        check("R3 ctrl alias", {24'b0, rv}, 32'h5E);
        check("R4 chars_o", chars_o, 32'h336657C1);
        check("R4 attr bit", {31'b0, chars_o[7]}, 32'h1);
        check("R5 fields", {26'b0, lamp_test_o, blink_all_o, blink_en_o, clear_o, bright_o},
              {26'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10});

        // R2 deselected writes and read
        ce0_n = 1'b1;
        bus_write(3'b100, 8'h11);
        ce0_n = 1'b0; ce1 = 1'b0;
        bus_write(3'b100, 8'h12);
        @(negedge clk);
        addr = 3'b100; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 no drive", {31'b0, data_io === 8'hC1}, 32'h0);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        ce1 = 1'b1;
        bus_read(3'b100, rv);
        check("R2 write ignored", {24'b0, rv}, 32'hC1);
        check("R6 read drive", {31'b0, rv === 8'hC1}, 32'h1);

        // R7 both strobes low
        @(negedge clk);
        addr = 3'b101; tb_dq = 8'h22; tb_oe = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        tb_oe = 1'b0;
        @(negedge clk);
        check("R7 no drive", {31'b0, data_io === 8'h57}, 32'h0);
        tb_oe = 1'b1;
        wr_n = 1'b1; rd_n = 1'b1;
        repeat (3) @(negedge clk);
        tb_oe = 1'b0;
        bus_read(3'b101, rv);
        check("R7 no write", {24'b0, rv}, 32'h57);

        // R8 held strobe, data changes mid pulse
        @(negedge clk);
        addr = 3'b110; tb_dq = 8'h44; tb_oe = 1'b1; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        tb_dq = 8'h99;
        repeat (10) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        tb_oe = 1'b0;
        bus_read(3'b110, rv);
        check("R8 single commit", {24'b0, rv}, 32'h44);

        // R9 start clear
        bus_write(3'b000, 8'hDE);
        check("R9 busy", {31'b0, busy_o}, 32'h1);
        check("R9 blank fill", chars_o, 32'h20202020);
        // R11 writes during busy
        bus_write(3'b100, 8'h77);
        bus_write(3'b000, 8'h01);
        repeat (CLR + 10) @(negedge clk);
        check("R13 busy done", {31'b0, busy_o}, 32'h0);
        bus_read(3'b000, rv);
        check("R11 ctrl kept", {24'b0, rv}, 32'hDE);
        bus_read(3'b100, rv);
        check("R11 char kept", {24'b0, rv}, 32'h20);
        // R12 char write with clear held
        bus_write(3'b111, 8'h55);
        bus_read(3'b111, rv);
        check("R12 clear lock", {24'b0, rv}, 32'h20);

        // R10 release clear
        bus_write(3'b000, 8'h03);
        check("R10 busy", {31'b0, busy_o}, 32'h1);
        check("R10 clear off", {31'b0, clear_o}, 32'h0);
        repeat (CLR + 10) @(negedge clk);
        check("R13 busy done 2", {31'b0, busy_o}, 32'h0);
        bus_write(3'b101, 8'hAB);
        bus_read(3'b101, rv);
        check("R10 write after", {24'b0, rv}, 32'hAB);
        check("R5 bright", {30'b0, bright_o}, 32'h3);

        // R1 reset mid run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 chars after reset", chars_o, 32'h0);
        bus_read(3'b000, rv);
        check("R1 ctrl after reset", {24'b0, rv}, 32'h0);

        finish_run();
    end

endmodule